// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers the processor's interrupt acknowledge cycles once an interrupt has been raised. It counts active-low acknowledge strobes and decides what goes onto the data bus for each one. It also produces a one-cycle strobe that tells the surrounding controller to move the winning request level into service.

Two processor styles are supported.

- **Byte-wide mode:** each interrupt takes three strobes. The first strobe returns a subroutine call opcode. The second and third return the low and then the high byte of a service routine address. That address is a programmed base plus the level number times a programmed entry spacing of 4 or 8 bytes.
- **Word-wide mode:** each interrupt takes two strobes. The first strobe only accepts the request and leaves the bus undriven. The second returns one type byte. Its upper bits come from a programmed base and its low three bits are the level number.

The strobe is brought into the clock domain through a parameterised synchronizer. The bus enable and data byte leave the block from registers.

Top module: `iack_vector_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `bus_oe`, `bus_data` and `commit` are all 0. The next strobe is then treated as the first of a sequence.
- R2: With `word_mode` = 0 at the first strobe of a sequence, that strobe drives `bus_oe` = 1 with `bus_data` = 8'hCD.
- R3: In byte-wide mode, the second strobe returns bits [7:0] and the third returns bits [15:8] of `isr_base` + level × S. S is 4 when `wide_gap` = 0 and 8 when `wide_gap` = 1, and the sum is taken modulo 2^16.
- R4: In byte-wide mode, the strobe after the third one starts a new sequence and returns 8'hCD again.
- R5: With `word_mode` = 1 at the first strobe of a sequence, `bus_oe` stays 0 for that whole strobe.
- R6: In word-wide mode, the second strobe returns {`type_base`[7:3], level}. The strobe after it starts a new sequence.
- R7: `bus_oe` is 1 only in cycles where the synchronized strobe was low in the previous cycle. Once the strobe has been high for SYNC_STAGES+1 cycles, `bus_oe` is 0.
- R8: `commit` pulses for exactly one cycle on the first strobe of each sequence, with `commit_level` equal to `win_level` at that strobe. It does not pulse on later strobes of the same sequence.
- R9: The level and the mode are captured at the first strobe. Changing `win_level` or `word_mode` during the rest of the sequence has no effect on the bytes returned or on the sequence length.
- R10: Asserting `rst` in the middle of a sequence abandons it. The next strobe is a first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_n | input | 1 | Interrupt acknowledge strobe, active low, asynchronous |
| word_mode | input | 1 | 1 = two-strobe type-byte mode, 0 = three-strobe call mode |
| wide_gap | input | 1 | Entry spacing for call mode: 0 = 4 bytes, 1 = 8 bytes |
| isr_base | input | 16 | Base address of the service routine table (call mode) |
| type_base | input | 8 | Type byte base; bits [7:3] are used (type mode) |
| win_level | input | 3 | Winning level from the priority logic |
| bus_oe | output | 1 | Data bus drive enable |
| bus_data | output | 8 | Byte to drive onto the data bus |
| commit | output | 1 | One-cycle strobe: put `commit_level` in service |
| commit_level | output | 3 | Level being committed |

## Verification
The assertions check the following properties on every cycle:
- The bus enable never rises without a preceding low strobe.
- `commit` never lasts two cycles.
- The captured level holds still between first strobes.
- A word-mode first strobe leaves the bus quiet.
- The outputs are clear right after reset.

The actual byte values need the bench's scenarios. These include the call opcode, the address sums with carry into the high byte under both spacings, and the type byte. The scenarios also show that a sequence wraps after its last strobe, that mode and level changes mid-sequence are ignored, and that a mid-sequence reset restarts the count.

// File: rtl/iack_seq_pkg.sv
package iack_seq_pkg;
  // What a given acknowledge strobe returns on the bus.
  typedef enum logic [2:0] {
    ROLE_NONE = 3'd0,
    ROLE_CALL = 3'd1,
    ROLE_LO   = 3'd2,
    ROLE_HI   = 3'd3,
    ROLE_TYPE = 3'd4
  } strobe_role_e;

  localparam int unsigned PULSES_BYTE_MODE = 3;
  localparam int unsigned PULSES_WORD_MODE = 2;
endpackage

// File: rtl/ack_strobe_sync.sv
module ack_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  output logic ack_low,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= ack_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign ack_low = ~chain[STAGES-1];
  assign fall    = prev & ~chain[STAGES-1];
  assign rise    = ~prev & chain[STAGES-1];
endmodule

// File: rtl/ack_pulse_counter.sv
module ack_pulse_counter
  import iack_seq_pkg::*;
#(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             rise,
  input  logic             word_mode,
  input  logic [LVL_W-1:0] win_level,
  output strobe_role_e     role_q,
  output logic             live_q,
  output logic             mode_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic             commit_q,
  output logic [LVL_W-1:0] commit_lvl_q
);
  localparam int unsigned CNT_W = $clog2(PULSES_BYTE_MODE);

  logic [CNT_W-1:0] cnt_q;
  logic             first;
  logic             eff_mode;
  logic [CNT_W-1:0] last_idx;
  strobe_role_e     role_d;

  assign first    = fall && (cnt_q == '0);
  assign eff_mode = first ? word_mode : mode_q;
  assign last_idx = eff_mode ? CNT_W'(PULSES_WORD_MODE - 1) : CNT_W'(PULSES_BYTE_MODE - 1);

  always_comb begin
    role_d = ROLE_NONE;
    if (eff_mode) begin
      if (cnt_q == CNT_W'(1)) role_d = ROLE_TYPE;
    end else begin
      unique case (cnt_q)
        CNT_W'(0): role_d = ROLE_CALL;
        CNT_W'(1): role_d = ROLE_LO;
        CNT_W'(2): role_d = ROLE_HI;
        default:   role_d = ROLE_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      role_q       <= ROLE_NONE;
      live_q       <= 1'b0;
      mode_q       <= 1'b0;
      lvl_q        <= '0;
      commit_q     <= 1'b0;
      commit_lvl_q <= '0;
    end else begin
      commit_q <= first;
      if (fall) begin
        cnt_q  <= (cnt_q == last_idx) ? '0 : cnt_q + CNT_W'(1);
        role_q <= role_d;
        live_q <= 1'b1;
      end else if (rise) begin
        live_q <= 1'b0;
      end
      if (first) begin
        mode_q       <= word_mode;
        lvl_q        <= win_level;
        commit_lvl_q <= win_level;
      end
    end
  end

  a_r8_commit_one_cycle: assert property (@(posedge clk) disable iff (rst)
    commit_q |=> !commit_q);

  a_r9_level_held: assert property (@(posedge clk) disable iff (rst)
    !(fall && cnt_q == '0) |=> $stable(lvl_q));

  a_r6_word_count_bound: assert property (@(posedge clk) disable iff (rst)
    (mode_q && cnt_q != '0) |-> cnt_q == CNT_W'(1));
endmodule

// File: rtl/vector_byte_gen.sv
module vector_byte_gen
  import iack_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned ADDR_W  = 16,
  parameter logic [7:0]  CALL_OP = 8'hCD
) (
  input  strobe_role_e      role,
  input  logic [LVL_W-1:0]  lvl,
  input  logic              wide_gap,
  input  logic [ADDR_W-1:0] isr_base,
  input  logic [DATA_W-1:0] type_base,
  output logic [DATA_W-1:0] byte_out
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] entry_addr;

  assign offset     = wide_gap ? (ADDR_W'(lvl) << 3) : (ADDR_W'(lvl) << 2);
  assign entry_addr = isr_base + offset;

  always_comb begin
    unique case (role)
      ROLE_CALL: byte_out = DATA_W'(CALL_OP);
      ROLE_LO:   byte_out = entry_addr[DATA_W-1:0];
      ROLE_HI:   byte_out = entry_addr[2*DATA_W-1:DATA_W];
      ROLE_TYPE: byte_out = {type_base[DATA_W-1:LVL_W], lvl};
      default:   byte_out = '0;
    endcase
  end
endmodule

// File: rtl/bus_drive_stage.sv
module bus_drive_stage
  import iack_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_low,
  input  logic              live,
  input  strobe_role_e      role,
  input  logic [DATA_W-1:0] byte_in,
  output logic              oe_q,
  output logic [DATA_W-1:0] data_q
);
  logic drive;
  assign drive = ack_low && live && (role != ROLE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      oe_q   <= drive;
      data_q <= drive ? byte_in : '0;
    end
  end

  a_r7_oe_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> $past(ack_low));
endmodule

// File: rtl/iack_vector_seq.sv
module iack_vector_seq
  import iack_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  CALL_OP     = 8'hCD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_n,
  input  logic              word_mode,
  input  logic              wide_gap,
  input  logic [ADDR_W-1:0] isr_base,
  input  logic [DATA_W-1:0] type_base,
  input  logic [LVL_W-1:0]  win_level,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data,
  output logic              commit,
  output logic [LVL_W-1:0]  commit_level
);
  logic              ack_low, fall, rise;
  strobe_role_e      role;
  logic              live, mode_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [DATA_W-1:0] next_byte;

  ack_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ack_n(ack_n),
    .ack_low(ack_low), .fall(fall), .rise(rise)
  );

  ack_pulse_counter #(.LVL_W(LVL_W)) u_count (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise),
    .word_mode(word_mode), .win_level(win_level),
    .role_q(role), .live_q(live), .mode_q(mode_q), .lvl_q(lvl_q),
    .commit_q(commit), .commit_lvl_q(commit_level)
  );

  vector_byte_gen #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .CALL_OP(CALL_OP)
  ) u_gen (
    .role(role), .lvl(lvl_q), .wide_gap(wide_gap),
    .isr_base(isr_base), .type_base(type_base), .byte_out(next_byte)
  );

  bus_drive_stage #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst(rst), .ack_low(ack_low), .live(live),
    .role(role), .byte_in(next_byte),
    .oe_q(bus_oe), .data_q(bus_data)
  );

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_oe && !commit && bus_data == '0));

  a_r5_word_first_quiet: assert property (@(posedge clk) disable iff (rst)
    (commit && mode_q) |=> !bus_oe);
endmodule

// File: tb/iack_vector_seq_tb_top.sv
module iack_vector_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ack_n = 1'b1;
  logic        word_mode = 1'b0;
  logic        wide_gap = 1'b0;
  logic [15:0] isr_base = '0;
  logic [7:0]  type_base = '0;
  logic [2:0]  win_level = '0;
  logic        bus_oe;
  logic [7:0]  bus_data;
  logic        commit;
  logic [2:0]  commit_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       oe;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t       bus_q[$];
  logic [2:0] commit_q[$];
  event       sample_ev;

  always #4 clk = ~clk;

  iack_vector_seq dut_i (
    .clk(clk), .rst(rst), .ack_n(ack_n), .word_mode(word_mode),
    .wide_gap(wide_gap), .isr_base(isr_base), .type_base(type_base),
    .win_level(win_level), .bus_oe(bus_oe), .bus_data(bus_data),
    .commit(commit), .commit_level(commit_level)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] entry(input logic [15:0] b, input logic [2:0] l, input bit g);
    return b + 16'(l) * (g ? 16'd8 : 16'd4);
  endfunction

  // Driver: one acknowledge strobe with an expected bus result.
  task automatic strobe(input logic oe, input logic [7:0] d, input string tag);
    exp_t e;
    e.oe = oe; e.data = d; e.tag = tag;
    bus_q.push_back(e);
    ack_n = 1'b0;
    repeat (8) @(negedge clk);
    -> sample_ev;
    @(negedge clk);
    ack_n = 1'b1;
    repeat (8) @(negedge clk);
    check(bus_oe == 1'b0, "R7 bus released after strobe", bus_oe, 0);
  endtask

  // Bus monitor.
  initial begin
    forever begin
      @(sample_ev);
      if (bus_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", 0, 1);
      end else begin
        exp_t e;
        e = bus_q.pop_front();
        check(bus_oe == e.oe, {e.tag, " oe"}, bus_oe, e.oe);
        if (e.oe) check(bus_data == e.data, {e.tag, " data"}, bus_data, e.data);
      end
    end
  end

  // Commit monitor (R8).
  always @(negedge clk) begin
    if (!rst && commit) begin
      if (commit_q.size() == 0) begin
        check(1'b0, "R8 unexpected commit", commit_level, 0);
      end else begin
        logic [2:0] x;
        x = commit_q.pop_front();
        check(commit_level == x, "R8 commit level", commit_level, x);
      end
    end
  end

  initial begin
    repeat (50000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    repeat (4) @(negedge clk);
    check(bus_oe == 0 && commit == 0 && bus_data == 0, "R1 reset state", bus_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    check(bus_oe == 0 && commit == 0, "R1 after reset", bus_oe, 0);

    // R2 R3 R4: byte mode, spacing 4.
    word_mode = 0; wide_gap = 0; isr_base = 16'h1230; win_level = 3'd5;
    a = entry(16'h1230, 3'd5, 1'b0);
    commit_q.push_back(3'd5);
    strobe(1, 8'hCD, "R2 call opcode");
    strobe(1, a[7:0], "R3 low byte gap4");
    strobe(1, a[15:8], "R3 high byte gap4");

    // R4: wraps, spacing 8 with carry into high byte.
    wide_gap = 1; isr_base = 16'hABF0; win_level = 3'd7;
    a = entry(16'hABF0, 3'd7, 1'b1);
    commit_q.push_back(3'd7);
    strobe(1, 8'hCD, "R4 new sequence call");
    strobe(1, a[7:0], "R3 low byte gap8");
    strobe(1, a[15:8], "R3 high byte gap8 carry");

    // R5 R6: word mode.
    word_mode = 1; type_base = 8'h4F; win_level = 3'd3;
    commit_q.push_back(3'd3);
    strobe(0, 8'h00, "R5 first strobe quiet");
    strobe(1, 8'h4B, "R6 type byte");
    commit_q.push_back(3'd1);
    win_level = 3'd1;
    strobe(0, 8'h00, "R6 next sequence quiet");
    // R9: mode and level changes mid-sequence ignored.
    word_mode = 0; win_level = 3'd6;
    strobe(1, 8'h49, "R9 type byte keeps level and mode");

    // Now byte mode sequence with level change mid-sequence (R9).
    wide_gap = 0; isr_base = 16'h0100; win_level = 3'd2;
    a = entry(16'h0100, 3'd2, 1'b0);
    commit_q.push_back(3'd2);
    strobe(1, 8'hCD, "R9 call");
    win_level = 3'd4;
    word_mode = 1;
    strobe(1, a[7:0], "R9 low byte latched level");
    strobe(1, a[15:8], "R9 high byte latched level");

    // R10: reset mid-sequence.
    word_mode = 0; win_level = 3'd0;
    commit_q.push_back(3'd0);
    strobe(1, 8'hCD, "R10 call before reset");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(bus_oe == 0 && commit == 0, "R1 after mid-sequence reset", bus_oe, 0);
    win_level = 3'd6;
    commit_q.push_back(3'd6);
    strobe(1, 8'hCD, "R10 restart call");

    repeat (4) @(negedge clk);
    check(commit_q.size() == 0, "R8 all commits seen", commit_q.size(), 0);
    check(bus_q.size() == 0, "scoreboard drained", bus_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule